// File: doc/BRIEF.md
# Serial Converter Port with Shared Data-Ready Output

This block is the host-facing serial port of a measurement converter. A host moves bits in on `din` and out on `dout_rdy_n` under its own serial clock, and frames transfers with an active-low select. Every exchange begins with an 8-bit command byte. That byte says whether the next transfer reads or writes, and which internal register it addresses. The port holds the mode and configuration words that the rest of the converter uses. It also holds the most recent 24-bit conversion result, which the converter core delivers through a one-cycle strobe.

The output pin has two jobs. While no read is shifting, it shows an active-low data-ready flag. The flag falls when a fresh result is loaded. It rises when the result has been read in full, when the core warns that an update is imminent, or when the synchronisation input is held low. In continuous-read mode, each new result shifts out on the serial clock with no command in front of it, and can be fetched only once. The port also runs with the select tied low permanently. In that case a run of 32 ones on `din` brings it back to a known state.

All serial pins are oversampled in the `clk` domain. Each level of the serial clock must last at least four `clk` cycles.

Top module: `adc_serial_port`

## Requirements
- R1: After `rst`, `dout_oe` is 0, the internal ready flag is high (not ready), `mode_reg` equals MODE_RST (24'h080060), `cfg_reg` equals CFG_RST (24'h000117) and `flt_hold` is 0.
- R2: The command byte is taken MSB first on rising serial-clock edges. Bit 7 must be 0, bit 6 is 1 for read and 0 for write, bits 5:3 are the register address, bit 2 requests continuous read and bits 1:0 must be 0. A byte that breaks either fixed-bit rule is ignored, and the next byte is again a command.
- R3: A write command to address 1 (mode) or 2 (configuration) is followed by 24 data bits, MSB first, captured on rising edges. The register changes only when the 24th bit arrives. A write command to any other address has no data phase and changes nothing.
- R4: A read command makes the port drive register bits on the pin, MSB first. Each bit changes after a falling edge and is stable at the following rising edge. Addresses 1, 2 and 3 (data) give 24 bits. Address 0 (status) gives 8 bits: bit 7 is the ready flag and the rest are 0. Addresses 4 to 7 give 8 zero bits.
- R5: `dout_oe` is 1 only while the select is low. Raising the select abandons a partial frame, so the next byte after it falls again is a command.
- R6: Outside a read, the pin shows the ready flag. A `conv_valid` strobe loads `conv_data` into the data register and drives the flag low. A strobe outranks every clearing event except synchronisation.
- R7: A complete 24-bit read of the data register sets the flag high. Outside continuous-read mode, the same result can be read again and returns the same value.
- R8: A `conv_soon` pulse sets the flag high. The next `conv_valid` drives it low again.
- R9: While `sync_n` is low, the flag is forced high and `flt_hold` is 1. The mode and configuration registers and the serial state are left untouched.
- R10: A read command to address 3 with bit 2 set enters continuous-read mode. From then on, each falling edge seen while the flag is low starts a 24-bit result read with no command, and the flag rises when that read completes. While the flag is high, the pin stays high, so extra clocks read all ones.
- R11: 32 consecutive ones on `din` return the port to waiting for a command and leave continuous-read mode.
- R12: All of the above works with the select held low for the whole session (three-wire use).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Host serial clock, idle high |
| cs_n | input | 1 | Active-low transfer select |
| din | input | 1 | Serial data from the host |
| dout_rdy_n | output | 1 | Serial data out, or the active-low ready flag when not reading |
| dout_oe | output | 1 | Output enable for the pin; 0 means high impedance |
| sync_n | input | 1 | Active-low synchronisation of the filter side |
| conv_soon | input | 1 | Pulse from the core just before a result update |
| conv_valid | input | 1 | One-cycle strobe: new result on `conv_data` |
| conv_data | input | 24 | Offset-binary conversion result |
| mode_reg | output | 24 | Current mode word |
| cfg_reg | output | 24 | Current configuration word |
| flt_hold | output | 1 | Holds filter and calibration control in reset while synchronising |

## Verification
The checker watches the ready-flag arbitration on every cycle: a strobe lowers the flag, and each clearing source raises it in the cycle after it fires. It also checks that the output enable drops after the select is released, and that the mode and configuration words move only on a completed write. Command decoding, bit ordering on the pin, the 8-bit and 24-bit read lengths, read-once behaviour in continuous mode, re-reading in normal mode, frame abort and the 32-ones recovery all depend on whole serial sequences. Only the bench scenarios can show them, by comparing the shifted-out words and the idle pin level against a behavioural model.

// File: rtl/adcsp_pkg.sv
package adcsp_pkg;

  localparam int ADDR_W = 3;

  // command byte field positions (decoded by the engine)
  localparam int CMD_START_BIT = 7;
  localparam int CMD_RD_BIT    = 6;
  localparam int CMD_ADDR_LSB  = 3;
  localparam int CMD_CR_BIT    = 2;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,   // collecting a command byte
    PH_WR  = 2'd1,   // collecting write data
    PH_RD  = 2'd2,   // shifting a register out
    PH_CRW = 2'd3    // continuous read, waiting for a result
  } phase_t;

endpackage

// File: rtl/adcsp_sync.sv
module adcsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic din_s
);

  // sck_p[STAGES] is the previous synchronised level, for edge detection
  logic [STAGES:0]   sck_p;
  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] din_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '1;
      cs_p  <= '1;
      din_p <= '0;
    end else begin
      sck_p <= {sck_p[STAGES-1:0], sclk};
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      din_p <= {din_p[STAGES-2:0], din};
    end
  end

  assign sclk_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
  assign sclk_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
  assign cs_act    = ~cs_p[STAGES-1];
  assign din_s     = din_p[STAGES-1];

endmodule

// File: rtl/adcsp_rdy.sv
module adcsp_rdy (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  input  logic conv_soon,
  input  logic conv_valid,
  input  logic rd_done,
  output logic rdy_n,
  output logic flt_hold
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n    <= 1'b1;
      flt_hold <= 1'b0;
    end else begin
      flt_hold <= ~sync_n;
      if (!sync_n)
        rdy_n <= 1'b1;
      else if (conv_valid)
        rdy_n <= 1'b0;
      else if (conv_soon || rd_done)
        rdy_n <= 1'b1;
    end
  end

endmodule

// File: rtl/adcsp_regs.sv
module adcsp_regs
  import adcsp_pkg::*;
#(
  parameter int          DW       = 24,
  parameter logic [DW-1:0] MODE_RST = 24'h080060,
  parameter logic [DW-1:0] CFG_RST  = 24'h000117
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              conv_valid,
  input  logic [DW-1:0]     conv_data,
  input  logic              rdy_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_word,
  output logic [DW-1:0]     mode_q,
  output logic [DW-1:0]     cfg_q,
  output logic [DW-1:0]     data_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RST;
      cfg_q  <= CFG_RST;
      data_q <= '0;
    end else begin
      if (wr_en && wr_addr == A_MODE) mode_q <= wr_data;
      if (wr_en && wr_addr == A_CFG)  cfg_q  <= wr_data;
      if (conv_valid)                 data_q <= conv_data;
    end
  end

  // read words are left aligned so the shifter always starts at the MSB
  always_comb begin
    case (rd_addr)
      A_STAT:  rd_word = {rdy_n, {(DW-1){1'b0}}};
      A_MODE:  rd_word = mode_q;
      A_CFG:   rd_word = cfg_q;
      A_DATA:  rd_word = data_q;
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/adcsp_engine.sv
module adcsp_engine
  import adcsp_pkg::*;
#(
  parameter int DW   = 24,
  parameter int CW   = 8,
  parameter int ONES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              fall,
  input  logic              cs_act,
  input  logic              din_s,
  input  logic              rdy_n,
  input  logic [DW-1:0]     rd_word,
  input  logic [DW-1:0]     data_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DW-1:0]     wr_data,
  output logic              rd_done,
  output logic              pin_q,
  output logic              oe_q
);

  localparam int CNTW = $clog2(DW + 1);
  localparam int OW   = $clog2(ONES + 1);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(CW - 1);
  localparam logic [CNTW-1:0] LAST_W = CNTW'(DW - 1);
  localparam logic [OW-1:0]   ONES_LAST = OW'(ONES - 1);

  phase_t              phase;
  logic [CNTW-1:0]     cnt;
  logic [OW-1:0]       ones;
  logic [DW-2:0]       sin;
  logic [DW-1:0]       sh;
  logic [ADDR_W-1:0]   addr_q;
  logic                short_q;
  logic                dat_q;
  logic                out_bit;
  logic                cread_q;

  logic [CW-1:0]       cmd_now;
  logic [ADDR_W-1:0]   cmd_addr;
  logic                cmd_ok;
  logic                cmd_long;

  assign cmd_now  = {sin[CW-2:0], din_s};
  assign cmd_addr = cmd_now[CMD_ADDR_LSB +: ADDR_W];
  assign cmd_ok   = !cmd_now[CMD_START_BIT] && (cmd_now[1:0] == 2'b00);
  assign cmd_long = (cmd_addr == A_MODE) || (cmd_addr == A_CFG) || (cmd_addr == A_DATA);
  assign rd_addr  = cmd_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_CMD;
      cnt     <= '0;
      ones    <= '0;
      sin     <= '0;
      sh      <= '0;
      addr_q  <= '0;
      short_q <= 1'b0;
      dat_q   <= 1'b0;
      out_bit <= 1'b1;
      cread_q <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      rd_done <= 1'b0;
      pin_q   <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      wr_en   <= 1'b0;
      rd_done <= 1'b0;
      oe_q    <= cs_act;
      pin_q   <= (phase == PH_RD) ? out_bit : rdy_n;

      if (!cs_act) begin
        phase <= cread_q ? PH_CRW : PH_CMD;
        cnt   <= '0;
        ones  <= '0;
      end else if (rise && din_s && ones == ONES_LAST) begin
        phase   <= PH_CMD;
        cread_q <= 1'b0;
        cnt     <= '0;
        ones    <= '0;
      end else begin
        if (rise) ones <= din_s ? ones + 1'b1 : '0;

        case (phase)
          PH_CMD: begin
            if (rise) begin
              sin <= {sin[DW-3:0], din_s};
              if (cnt == LAST_C) begin
                cnt <= '0;
                if (cmd_ok) begin
                  if (cmd_now[CMD_RD_BIT]) begin
                    if (cmd_addr == A_DATA && cmd_now[CMD_CR_BIT]) begin
                      cread_q <= 1'b1;
                      phase   <= PH_CRW;
                    end else begin
                      sh      <= rd_word;
                      short_q <= !cmd_long;
                      dat_q   <= (cmd_addr == A_DATA);
                      phase   <= PH_RD;
                    end
                  end else if (cmd_addr == A_MODE || cmd_addr == A_CFG) begin
                    addr_q <= cmd_addr;
                    phase  <= PH_WR;
                  end
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end

          PH_WR: begin
            if (rise) begin
              sin <= {sin[DW-3:0], din_s};
              if (cnt == LAST_W) begin
                cnt     <= '0;
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= {sin, din_s};
                phase   <= PH_CMD;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end

          PH_RD: begin
            if (fall) begin
              out_bit <= sh[DW-1];
              sh      <= {sh[DW-2:0], 1'b0};
            end
            if (rise) begin
              if (cnt == (short_q ? LAST_C : LAST_W)) begin
                cnt   <= '0;
                phase <= cread_q ? PH_CRW : PH_CMD;
                if (dat_q) rd_done <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end

          PH_CRW: begin
            if (fall && !rdy_n) begin
              out_bit <= data_q[DW-1];
              sh      <= {data_q[DW-2:0], 1'b0};
              short_q <= 1'b0;
              dat_q   <= 1'b1;
              cnt     <= '0;
              phase   <= PH_RD;
            end
          end

          default: phase <= PH_CMD;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adcsp_pkg::*;
#(
  parameter int            DW       = 24,
  parameter int            CW       = 8,
  parameter int            ONES     = 32,
  parameter int            STAGES   = 2,
  parameter logic [DW-1:0] MODE_RST = 24'h080060,
  parameter logic [DW-1:0] CFG_RST  = 24'h000117
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  output logic          dout_rdy_n,
  output logic          dout_oe,
  input  logic          sync_n,
  input  logic          conv_soon,
  input  logic          conv_valid,
  input  logic [DW-1:0] conv_data,
  output logic [DW-1:0] mode_reg,
  output logic [DW-1:0] cfg_reg,
  output logic          flt_hold
);

  logic              sclk_rise;
  logic              sclk_fall;
  logic              cs_act;
  logic              din_s;
  logic              rdy_n;
  logic              rd_done;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DW-1:0]     wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DW-1:0]     rd_word;
  logic [DW-1:0]     data_q;

  adcsp_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .din_s(din_s)
  );

  adcsp_rdy u_rdy (
    .clk(clk), .rst(rst), .sync_n(sync_n), .conv_soon(conv_soon),
    .conv_valid(conv_valid), .rd_done(rd_done), .rdy_n(rdy_n), .flt_hold(flt_hold)
  );

  adcsp_regs #(.DW(DW), .MODE_RST(MODE_RST), .CFG_RST(CFG_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .conv_valid(conv_valid), .conv_data(conv_data), .rdy_n(rdy_n),
    .rd_addr(rd_addr), .rd_word(rd_word), .mode_q(mode_reg), .cfg_q(cfg_reg),
    .data_q(data_q)
  );

  adcsp_engine #(.DW(DW), .CW(CW), .ONES(ONES)) u_eng (
    .clk(clk), .rst(rst), .rise(sclk_rise), .fall(sclk_fall), .cs_act(cs_act),
    .din_s(din_s), .rdy_n(rdy_n), .rd_word(rd_word), .data_q(data_q),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_done(rd_done), .pin_q(dout_rdy_n), .oe_q(dout_oe)
  );

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
  import adcsp_pkg::*;
#(
  parameter int DW = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_act,
  input logic              dout_oe,
  input logic              sync_n,
  input logic              conv_valid,
  input logic              conv_soon,
  input logic              rdy_n,
  input logic              rd_done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     mode_reg,
  input logic [DW-1:0]     cfg_reg
);

  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !dout_oe); // R5

  AST_STROBE_LOWERS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sync_n && conv_valid) |=> !rdy_n); // R6

  AST_DATA_READ_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !conv_valid && rd_done) |=> rdy_n); // R7

  AST_WARNING_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    (sync_n && !conv_valid && conv_soon) |=> rdy_n); // R8

  AST_SYNC_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
    !sync_n |=> rdy_n); // R9

  AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_MODE) |=> $stable(mode_reg)); // R3

  AST_CFG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == A_CFG) |=> $stable(cfg_reg)); // R3

endmodule

bind adc_serial_port adc_serial_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cs_act(cs_act), .dout_oe(dout_oe), .sync_n(sync_n),
  .conv_valid(conv_valid), .conv_soon(conv_soon), .rdy_n(rdy_n),
  .rd_done(rd_done), .wr_en(wr_en), .wr_addr(wr_addr),
  .mode_reg(mode_reg), .cfg_reg(cfg_reg)
);

// File: tb/adc_serial_port_bench.sv
`timescale 1ns/1ps
module adc_serial_port_bench;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        sync_n = 1'b1;
  logic        conv_soon = 1'b0;
  logic        conv_valid = 1'b0;
  logic [23:0] conv_data = '0;
  logic        dout_rdy_n;
  logic        dout_oe;
  logic [23:0] mode_reg;
  logic [23:0] cfg_reg;
  logic        flt_hold;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  bit watch = 0;

  // behavioural reference state
  logic [23:0] exp_mode = 24'h080060;
  logic [23:0] exp_cfg  = 24'h000117;
  logic [23:0] exp_data = '0;
  logic        exp_rdy  = 1'b1;

  always #2 clk = ~clk;

  adc_serial_port u_adc_serial_port (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout_rdy_n(dout_rdy_n), .dout_oe(dout_oe), .sync_n(sync_n),
    .conv_soon(conv_soon), .conv_valid(conv_valid), .conv_data(conv_data),
    .mode_reg(mode_reg), .cfg_reg(cfg_reg), .flt_hold(flt_hold)
  );

  // per-clock comparison of the register outputs against the model (R3, R9)
  always @(negedge clk) begin
    if (watch && !rst) begin
      nchk++;
      if (mode_reg !== exp_mode || cfg_reg !== exp_cfg) begin
        nfail++;
        $display("FAIL R3 R9 regs act=%h/%h exp=%h/%h", mode_reg, cfg_reg, exp_mode, exp_cfg);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [2:0] a, input bit cr);
    return {24'h0, 1'b0, rd, a, cr, 2'b00};
  endfunction

  task automatic xfer(input logic [31:0] tx, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sclk = 1'b0;
      din  = tx[i];
      tick(HALF);
      rx   = {rx[30:0], dout_rdy_n};
      sclk = 1'b1;
      tick(HALF);
    end
    din = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] v);
    logic [31:0] junk;
    xfer(cmd(1'b1, a, 1'b0), 8, junk);
    xfer(32'h0, n, v);
    tick(6);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [23:0] v);
    logic [31:0] junk;
    watch = 0;
    xfer(cmd(1'b0, a, 1'b0), 8, junk);
    xfer({8'h0, v}, 24, junk);
    tick(6);
    if (a == 3'd1) exp_mode = v;
    if (a == 3'd2) exp_cfg  = v;
    watch = 1;
  endtask

  task automatic conv(input logic [23:0] v);
    conv_data  = v;
    conv_valid = 1'b1;
    tick(1);
    conv_valid = 1'b0;
    tick(4);
    exp_data = v;
    exp_rdy  = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] junk;
    tick(6);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 oe", {31'h0, dout_oe}, 32'h0);
    check("R1 mode", {8'h0, mode_reg}, 32'h080060);
    check("R1 cfg", {8'h0, cfg_reg}, 32'h000117);
    check("R1 hold", {31'h0, flt_hold}, 32'h0);
    watch = 1;
    cs_n = 1'b0;
    tick(6);
    check("R1 R6 idle pin", {31'h0, dout_rdy_n}, 32'h1);
    check("R5 oe while selected", {31'h0, dout_oe}, 32'h1);

    // R3 R4 R12 writes and read-back, select kept low
    wr_reg(3'd1, 24'h123456);
    rd_reg(3'd1, 24, v);
    check("R3 R4 R12 mode readback", v, {8'h0, exp_mode});
    wr_reg(3'd2, 24'hA5C33C);
    rd_reg(3'd2, 24, v);
    check("R3 R4 cfg readback", v, {8'h0, exp_cfg});

    // R4 status and unused addresses
    rd_reg(3'd0, 8, v);
    check("R4 status not ready", v, 32'h80);
    rd_reg(3'd5, 8, v);
    check("R4 unused address", v, 32'h0);

    // R3 write to data address has no data phase
    xfer(cmd(1'b0, 3'd3, 1'b0), 8, junk);
    rd_reg(3'd1, 24, v);
    check("R3 write to data ignored", v, {8'h0, exp_mode});

    // R2 malformed command bytes are ignored
    xfer(32'hC8, 8, junk);
    rd_reg(3'd2, 24, v);
    check("R2 start bit set ignored", v, {8'h0, exp_cfg});
    xfer(32'h49, 8, junk);
    rd_reg(3'd1, 24, v);
    check("R2 reserved bits ignored", v, {8'h0, exp_mode});

    // R6 R7 conversion, status, data read and re-read
    conv(24'h801234);
    check("R6 flag low after result", {31'h0, dout_rdy_n}, 32'h0);
    rd_reg(3'd0, 8, v);
    check("R4 status ready", v, 32'h00);
    rd_reg(3'd3, 24, v);
    check("R7 data read", v, 32'h00801234);
    exp_rdy = 1'b1;
    check("R7 flag high after read", {31'h0, dout_rdy_n}, {31'h0, exp_rdy});
    rd_reg(3'd3, 24, v);
    check("R7 re-read same result", v, {8'h0, exp_data});

    // R8 warning before update
    conv(24'h7FFFFF);
    conv_soon = 1'b1;
    tick(1);
    conv_soon = 1'b0;
    tick(4);
    exp_rdy = 1'b1;
    check("R8 warning raises flag", {31'h0, dout_rdy_n}, {31'h0, exp_rdy});
    conv(24'h000001);
    check("R8 next result lowers flag", {31'h0, dout_rdy_n}, 32'h0);

    // R9 synchronisation
    sync_n = 1'b0;
    tick(5);
    exp_rdy = 1'b1;
    check("R9 sync raises flag", {31'h0, dout_rdy_n}, 32'h1);
    check("R9 hold asserted", {31'h0, flt_hold}, 32'h1);
    sync_n = 1'b1;
    tick(4);
    check("R9 hold released", {31'h0, flt_hold}, 32'h0);
    rd_reg(3'd2, 24, v);
    check("R9 serial side intact", v, {8'h0, exp_cfg});

    // R5 abandon a partial frame
    xfer(cmd(1'b1, 3'd1, 1'b0), 4, junk);
    cs_n = 1'b1;
    tick(6);
    check("R5 released pin", {31'h0, dout_oe}, 32'h0);
    cs_n = 1'b0;
    tick(6);
    rd_reg(3'd1, 24, v);
    check("R5 frame restarted", v, {8'h0, exp_mode});

    // R10 continuous read
    conv(24'hABCDEF);
    xfer(cmd(1'b1, 3'd3, 1'b1), 8, junk);
    tick(4);
    xfer(32'h0, 24, v);
    tick(6);
    check("R10 first result", v, 32'h00ABCDEF);
    check("R10 flag high after read", {31'h0, dout_rdy_n}, 32'h1);
    xfer(32'h0, 24, v);
    tick(6);
    check("R10 read only once", v, 32'h00FFFFFF);
    conv(24'h135790);
    xfer(32'h0, 24, v);
    tick(6);
    check("R10 next result no command", v, 32'h00135790);

    // R11 ones recovery leaves continuous read
    xfer(32'hFFFFFFFF, 32, junk);
    tick(4);
    conv(24'h2468AC);
    rd_reg(3'd0, 8, v);
    check("R11 command accepted after ones", v, 32'h00);
    check("R11 flag still low", {31'h0, dout_rdy_n}, 32'h0);
    rd_reg(3'd3, 24, v);
    check("R11 R12 normal data read", v, 32'h002468AC);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule